// File: doc/BRIEF.md
# Power-On Interface Mode Arbiter

This block decides which serial protocol owns the shared pins once reset is released. It first opens a start window. During the window only the one-wire interface is enabled, and the analog output pin carries one-wire traffic. A one-wire decoder outside this block raises a strobe when it recognises a valid request. If that strobe arrives while the window is open, the arbiter locks into one-wire mode. It stays there until a leave command strobe arrives or the block is reset again.

When the window runs out with no request, the pins pass to the bus protocol chosen by configuration, either I2C or SPI. At the same time the output pin goes back to analog or PWM use, as configured. A configuration bit can skip the window altogether, so that the configured bus mode is active from reset.

In SPI mode the second I/O pin becomes the slave-select input and the first I/O pin becomes the data output. A second PWM output may also be enabled on the first I/O pin. When it is, SPI traffic takes that pin for as long as slave select is active, and PWM is interrupted.

Top module: `ifc_mode_arbiter`

## Requirements
- R1: While reset is asserted with the window enabled, and until the first clock edge after release, `mode_ow` is 1, `win_open` is 1, and `out_sel` is 0. The encoding of `out_sel` is: 0 = one-wire, 1 = analog, 2 = PWM.
- R2: With the window enabled and no request, the block stays in one-wire mode through the first WIN_CYCLES-1 rising edges after reset release. From rising edge WIN_CYCLES onward it is in the configured bus mode and `win_open` is 0.
- R3: A request strobe sampled at any of rising edges 1 to WIN_CYCLES after release locks one-wire mode. This includes edge WIN_CYCLES itself, the edge at which the window expires.
- R4: Once locked, one-wire mode holds for any number of cycles and any request strobes. It ends only when `leave_cmd` is sampled, and the block is in bus mode from the next edge.
- R5: In bus mode, `cfg_bus_spi` = 1 enables SPI and `cfg_bus_spi` = 0 enables I2C. In bus mode, `out_sel` is 2 when `cfg_out_pwm` = 1 and 1 when `cfg_out_pwm` = 0.
- R6: With `cfg_win_dis` = 1, the configured bus mode is active from reset onward, `win_open` is 0, and request strobes have no effect.
- R7: `io2_ss` is 1 exactly in SPI mode. In SPI mode, `io1_sel` is 1 (SPI data out) while `io2_ss_in` is low, which means slave select is active. The encoding of `io1_sel` is: 0 = idle, 1 = SPI data out, 2 = PWM.
- R8: With `cfg_io1_pwm` = 1 in bus mode, `io1_sel` is 2 except while SPI data out holds the pin under R7. In one-wire mode, or with `cfg_io1_pwm` = 0 and no SPI traffic, `io1_sel` is 0.
- R9: Exactly one of `mode_ow`, `mode_i2c` and `mode_spi` is 1 at every sampled cycle.
- R10: `leave_cmd` has no effect while the window is open. A request strobe has no effect once bus mode has been entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that the window is counted in |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| ow_req | input | 1 | One-cycle strobe: valid one-wire request detected |
| leave_cmd | input | 1 | One-cycle strobe: command to leave one-wire mode |
| cfg_win_dis | input | 1 | 1 = skip the start window |
| cfg_bus_spi | input | 1 | Bus after the window: 1 = SPI, 0 = I2C |
| cfg_out_pwm | input | 1 | Output pin use in bus mode: 1 = PWM, 0 = analog |
| cfg_io1_pwm | input | 1 | 1 = second PWM output on IO1 |
| io2_ss_in | input | 1 | Slave-select level seen on IO2 (active low) |
| mode_ow | output | 1 | One-wire interface enabled |
| mode_i2c | output | 1 | I2C interface enabled |
| mode_spi | output | 1 | SPI interface enabled |
| win_open | output | 1 | Start window is running |
| out_sel | output | 2 | Output pin routing: 0 one-wire, 1 analog, 2 PWM |
| io1_sel | output | 2 | IO1 routing: 0 idle, 1 SPI data out, 2 PWM |
| io2_ss | output | 1 | IO2 acts as the slave-select input |

## Verification
The hardest case to reach from the ports is a request strobe that lands on exactly the edge where the window expires, since one cycle either way gives a different, legal result. Directed runs place the strobe on edge WIN_CYCLES and on edge WIN_CYCLES+1, counted from a reset release made on a falling edge. Random runs then mix the request position, the leave-command position, the configuration bits and the slave-select level from cycle to cycle. A cycle-accurate reference in the bench predicts every output at every cycle of these runs.

// File: rtl/ifc_mode_pkg.sv
package ifc_mode_pkg;

   typedef enum logic [1:0] {
      ST_WINDOW  = 2'd0,
      ST_OW_LOCK = 2'd1,
      ST_BUS     = 2'd2
   } arb_state_e;

   localparam logic [1:0] OUTR_OW     = 2'd0;
   localparam logic [1:0] OUTR_ANALOG = 2'd1;
   localparam logic [1:0] OUTR_PWM    = 2'd2;

   localparam logic [1:0] IO1R_IDLE   = 2'd0;
   localparam logic [1:0] IO1R_SDO    = 2'd1;
   localparam logic [1:0] IO1R_PWM    = 2'd2;

endpackage

// File: rtl/ifc_win_timer.sv
module ifc_win_timer #(
   parameter int WIN_CYCLES = 40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

   generate
      if (WIN_CYCLES < 2) begin : g_bad_len
         $error("ifc_win_timer: WIN_CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run && (cnt_q == LAST);

   // R2: the fsm must leave the window after one expiry
   p_single_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   // R2: count never passes the window end
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/ifc_mode_fsm.sv
module ifc_mode_fsm
   import ifc_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       ow_req,
   input  logic       leave_cmd,
   input  logic       cfg_win_dis,
   output arb_state_e state,
   output logic       run
);
   arb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_WINDOW: begin
            if (cfg_win_dis)      state_d = ST_BUS;
            else if (ow_req)      state_d = ST_OW_LOCK;
            else if (expire)      state_d = ST_BUS;
         end
         ST_OW_LOCK: begin
            if (leave_cmd)        state_d = ST_BUS;
         end
         ST_BUS:                  state_d = ST_BUS;
         default:                 state_d = ST_BUS;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_WINDOW;
      else        state_q <= state_d;
   end

   assign state = state_q;
   assign run   = (state_q == ST_WINDOW) && !cfg_win_dis;

   // R3: a request while the window runs locks one-wire mode
   p_req_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ow_req) |=> (state_q == ST_OW_LOCK));

   // R4: lock held unless a leave command is seen
   p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_OW_LOCK) && !leave_cmd) |=> (state_q == ST_OW_LOCK));

   // R4: a leave command ends the lock
   p_leave_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_OW_LOCK) && leave_cmd) |=> (state_q == ST_BUS));

   // R10: bus mode is final until reset
   p_bus_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BUS) |=> (state_q == ST_BUS));

endmodule

// File: rtl/ifc_pin_router.sv
module ifc_pin_router
   import ifc_mode_pkg::*;
#(
   parameter bit SS_ACTIVE_LOW = 1'b1
) (
   input  arb_state_e state,
   input  logic       cfg_win_dis,
   input  logic       cfg_bus_spi,
   input  logic       cfg_out_pwm,
   input  logic       cfg_io1_pwm,
   input  logic       ss_in,
   output logic       mode_ow,
   output logic       mode_i2c,
   output logic       mode_spi,
   output logic       win_open,
   output logic [1:0] out_sel,
   output logic [1:0] io1_sel,
   output logic       io2_ss
);
   logic ss_act;
   logic in_bus;

   generate
      if (SS_ACTIVE_LOW) begin : g_ss_low
         assign ss_act = ~ss_in;
      end else begin : g_ss_high
         assign ss_act = ss_in;
      end
   endgenerate

   assign win_open = (state == ST_WINDOW) && !cfg_win_dis;
   assign mode_ow  = win_open || (state == ST_OW_LOCK);
   assign in_bus   = !mode_ow;
   assign mode_spi = in_bus && cfg_bus_spi;
   assign mode_i2c = in_bus && !cfg_bus_spi;
   assign io2_ss   = mode_spi;

   always_comb begin
      if (mode_ow)          out_sel = OUTR_OW;
      else if (cfg_out_pwm) out_sel = OUTR_PWM;
      else                  out_sel = OUTR_ANALOG;
   end

   always_comb begin
      if (mode_spi && ss_act)         io1_sel = IO1R_SDO;
      else if (in_bus && cfg_io1_pwm) io1_sel = IO1R_PWM;
      else                            io1_sel = IO1R_IDLE;
   end

endmodule

// File: rtl/ifc_mode_arbiter.sv
module ifc_mode_arbiter
   import ifc_mode_pkg::*;
#(
   parameter int WIN_CYCLES    = 40000,
   parameter bit SS_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ow_req,
   input  logic       leave_cmd,
   input  logic       cfg_win_dis,
   input  logic       cfg_bus_spi,
   input  logic       cfg_out_pwm,
   input  logic       cfg_io1_pwm,
   input  logic       io2_ss_in,
   output logic       mode_ow,
   output logic       mode_i2c,
   output logic       mode_spi,
   output logic       win_open,
   output logic [1:0] out_sel,
   output logic [1:0] io1_sel,
   output logic       io2_ss
);
   arb_state_e state;
   logic       run;
   logic       expire;

   ifc_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .expire (expire)
   );

   ifc_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .expire      (expire),
      .ow_req      (ow_req),
      .leave_cmd   (leave_cmd),
      .cfg_win_dis (cfg_win_dis),
      .state       (state),
      .run         (run)
   );

   ifc_pin_router #(.SS_ACTIVE_LOW(SS_ACTIVE_LOW)) u_router (
      .state       (state),
      .cfg_win_dis (cfg_win_dis),
      .cfg_bus_spi (cfg_bus_spi),
      .cfg_out_pwm (cfg_out_pwm),
      .cfg_io1_pwm (cfg_io1_pwm),
      .ss_in       (io2_ss_in),
      .mode_ow     (mode_ow),
      .mode_i2c    (mode_i2c),
      .mode_spi    (mode_spi),
      .win_open    (win_open),
      .out_sel     (out_sel),
      .io1_sel     (io1_sel),
      .io2_ss      (io2_ss)
   );

   // R9: one protocol enable at a time
   p_onehot_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mode_ow, mode_i2c, mode_spi}) == 1);

   // R7: SPI data out only with SPI enabled
   p_sdo_needs_spi_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (io1_sel == IO1R_SDO) |-> (mode_spi && io2_ss));

   // R1: the output pin carries one-wire traffic whenever one-wire is enabled
   p_out_ow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ow |-> (out_sel == OUTR_OW));

   // R6: with the window skipped no one-wire mode ever appears
   p_skip_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_win_dis |-> (!win_open && !mode_ow));

endmodule

// File: tb/ifc_mode_arbiter_tb.sv
`timescale 1ns/1ps
module ifc_mode_arbiter_tb;
   localparam int WIN = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ow_req = 1'b0, leave_cmd = 1'b0;
   logic cfg_win_dis = 1'b0, cfg_bus_spi = 1'b0, cfg_out_pwm = 1'b0, cfg_io1_pwm = 1'b0;
   logic io2_ss_in = 1'b1;
   logic mode_ow, mode_i2c, mode_spi, win_open, io2_ss;
   logic [1:0] out_sel, io1_sel;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   // reference state: 0 window, 1 locked, 2 bus
   int m_st;
   int m_cnt;

   always #4 clk = ~clk;

   ifc_mode_arbiter #(.WIN_CYCLES(WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .ow_req(ow_req), .leave_cmd(leave_cmd),
      .cfg_win_dis(cfg_win_dis), .cfg_bus_spi(cfg_bus_spi),
      .cfg_out_pwm(cfg_out_pwm), .cfg_io1_pwm(cfg_io1_pwm),
      .io2_ss_in(io2_ss_in), .mode_ow(mode_ow), .mode_i2c(mode_i2c),
      .mode_spi(mode_spi), .win_open(win_open), .out_sel(out_sel),
      .io1_sel(io1_sel), .io2_ss(io2_ss)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic bit exp_ow();
      return (m_st == 1) || (m_st == 0 && !cfg_win_dis);
   endfunction

   function automatic int exp_modes();
      if (exp_ow()) return 4;
      return cfg_bus_spi ? 1 : 2;
   endfunction

   function automatic int exp_out();
      if (exp_ow()) return 0;
      return cfg_out_pwm ? 2 : 1;
   endfunction

   function automatic int exp_io1();
      if (!exp_ow() && cfg_bus_spi && !io2_ss_in) return 1;
      if (!exp_ow() && cfg_io1_pwm) return 2;
      return 0;
   endfunction

   task automatic model_edge(input bit req, input bit lv);
      if (m_st == 0) begin
         if (cfg_win_dis)          m_st = 2;
         else if (req)             m_st = 1;
         else if (m_cnt == WIN-1)  m_st = 2;
         else                      m_cnt++;
      end else if (m_st == 1) begin
         if (lv) m_st = 2;
      end
   endtask

   task automatic check_all();
      string mtag;
      if (cfg_win_dis)     mtag = "R6";
      else if (m_st == 0)  mtag = "R2";
      else if (m_st == 1)  mtag = "R4";
      else                 mtag = "R5";
      chk(mtag, {mode_ow, mode_i2c, mode_spi}, exp_modes());
      chk("R5", out_sel, exp_out());
      chk("R2", win_open, (m_st == 0 && !cfg_win_dis) ? 1 : 0);
      chk("R7", io2_ss, (!exp_ow() && cfg_bus_spi) ? 1 : 0);
      chk((exp_io1() == 1) ? "R7" : "R8", io1_sel, exp_io1());
      chk("R9", $countones({mode_ow, mode_i2c, mode_spi}), 1);
   endtask

   task automatic start(input bit dis, input bit spi, input bit opwm, input bit iopwm);
      @(negedge clk);
      rst_n = 1'b0; ow_req = 1'b0; leave_cmd = 1'b0; io2_ss_in = 1'b1;
      cfg_win_dis = dis; cfg_bus_spi = spi; cfg_out_pwm = opwm; cfg_io1_pwm = iopwm;
      repeat (2) @(negedge clk);
      m_st = 0; m_cnt = 0;
      if (!dis) begin
         chk("R1", mode_ow, 1);
         chk("R1", win_open, 1);
         chk("R1", out_sel, 0);
      end
      rst_n = 1'b1;
      #1 check_all();
   endtask

   task automatic run(input int req_edge, input int lv_edge, input int ncyc, input bit rand_ss);
      for (int k = 1; k <= ncyc; k++) begin
         ow_req    = (k == req_edge);
         leave_cmd = (k == lv_edge);
         io2_ss_in = rand_ss ? 1'($urandom_range(0, 1)) : 1'b1;
         @(posedge clk);
         model_edge(ow_req, leave_cmd);
         @(negedge clk);
         check_all();
      end
      ow_req = 1'b0; leave_cmd = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 200000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 200000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));

      // R1, R2: no request, I2C with analog output
      start(1'b0, 1'b0, 1'b0, 1'b0);
      run(0, 0, WIN + 4, 1'b0);
      chk("R2", mode_i2c, 1);

      // R3: request on the expiring edge still locks
      start(1'b0, 1'b1, 1'b1, 1'b0);
      run(WIN, 0, WIN + 6, 1'b1);
      chk("R3", mode_ow, 1);

      // R10: request one edge late is ignored, leave in window ignored
      start(1'b0, 1'b1, 1'b0, 1'b1);
      run(WIN + 1, 5, WIN + 6, 1'b1);
      chk("R10", mode_spi, 1);

      // R4: locked early, held long, leave later
      start(1'b0, 1'b0, 1'b1, 1'b1);
      run(1, 3 * WIN, 3 * WIN + 5, 1'b0);
      chk("R4", mode_i2c, 1);

      // R6: window skipped, request ignored
      start(1'b1, 1'b1, 1'b1, 1'b1);
      run(2, 0, 20, 1'b1);
      chk("R6", mode_spi, 1);

      // random mix
      for (int t = 0; t < 40; t++) begin
         start(($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         run($urandom_range(0, WIN + 10), $urandom_range(0, WIN + 40), WIN + 45, 1'b1);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule